// File: doc/BRIEF.md
# Carrier Sense and Collision Indication Unit

This unit produces the carrier-sense and collision indications that a PHY presents to its MAC, together with a collision LED drive. It takes a receive-activity flag from the media side, the MAC's transmit enable, the duplex setting, a repeater-mode control and an isolate control. In half duplex, carrier follows activity in either direction and a collision is flagged while both directions are busy. In full duplex, carrier follows receive only and the collision output is held low.

For 10 Mbit/s links the unit can emit a heartbeat (SQE test) pulse on the collision output after each transmission. The pulse has a fixed delay and width, and both are parameters. Repeater mode forces half-duplex behaviour and suppresses this heartbeat. Isolate removes the output enables of the MII outputs so that several PHYs can share one MAC. In repeater mode the carrier output keeps its drive.

Top module: `carrier_collision_unit`

## Requirements
- R1: With fullDuplex=1 and repeaterMode=0, crs equals rxActive in the same cycle and does not depend on txEn.
- R2: In half-duplex mode (fullDuplex=0, or repeaterMode=1), crs is high whenever rxActive or txEn is high, and low only when both are low.
- R3: In half-duplex mode, col is high in the same cycle that txEn and rxActive are both high.
- R4: With fullDuplex=1 and repeaterMode=0, col stays low for any activity, and no heartbeat pulse appears on it.
- R5: repeaterMode=1 overrides fullDuplex=1: crs and col behave as in half duplex.
- R6: With half duplex, repeaterMode=0 and sqeReq=1, call E0 the first rising clock edge at which txEn is sampled low after being high. col is then high from edge E0+SQE_DELAY through the cycle that ends at edge E0+SQE_DELAY+SQE_WIDTH, which is SQE_WIDTH cycles. If txEn rises again before the pulse ends, the pulse is dropped.
- R7: No heartbeat pulse appears when sqeReq=0 or repeaterMode=1.
- R8: With isolate=1, colOe is low. crsOe is low too unless repeaterMode=1. With isolate=0, both enables are high.
- R9: In half-duplex mode, ledCol inverts at the clock edge that first samples a collision (txEn and rxActive both high) after a sample without one. A collision held for several cycles inverts ledCol only once. Whenever full-duplex mode is sampled, ledCol is cleared to 0.
- R10: After reset, ledCol is 0 and col stays low while txEn and rxActive stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxActive | input | 1 | Receive medium is non-idle |
| txEn | input | 1 | Transmit enable from the MAC |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| repeaterMode | input | 1 | Repeater mode; forces half duplex and suppresses the heartbeat |
| isolate | input | 1 | Isolate the MII outputs |
| sqeReq | input | 1 | Enable the 10 Mbit/s heartbeat after transmit |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / heartbeat |
| crsOe | output | 1 | Output enable for crs |
| colOe | output | 1 | Output enable for col |
| ledCol | output | 1 | Collision LED drive |

## Verification
The combinational indications are swept over all 32 combinations of receive activity, transmit enable, duplex, repeater mode and isolate. This sweep shows how the duplex and repeater gating and the two separate output enables interact. The heartbeat is traced cycle by cycle after a transmit falling edge, with checks just before the start edge, inside the pulse and just after its end. These samples expose off-by-one errors in the delay and the width. Further runs check that the pulse is dropped when transmit restarts, and that it never appears in repeater mode, in full duplex or with the request off. The LED is driven with separate collisions and with one long collision, so a toggle on every onset can be told apart from a toggle on every cycle.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic sqeOn;    // heartbeat pulse window active
    logic ledFlip;  // collision onset seen this cycle
  } ccuStrobe_t;

  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_WAIT  = 2'd1,
    SQE_PULSE = 2'd2
  } sqeState_t;

endpackage

// File: rtl/ccu_ctrl.sv
module ccu_ctrl
  import ccu_pkg::*;
#(
  parameter int SQE_DELAY = 4,
  parameter int SQE_WIDTH = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       sqeAllowed,
  input  logic       colRaw,
  output ccuStrobe_t strobe
);

  localparam int MAX_SPAN = (SQE_DELAY > SQE_WIDTH) ? SQE_DELAY : SQE_WIDTH;
  localparam int CNT_W    = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1;
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(SQE_DELAY - 1);
  localparam logic [CNT_W-1:0] WIDTH_LAST = CNT_W'(SQE_WIDTH - 1);

  sqeState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             txPrev;
  logic             colPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SQE_IDLE;
      cnt     <= '0;
      txPrev  <= 1'b0;
      colPrev <= 1'b0;
    end else begin
      txPrev  <= txEn;
      colPrev <= colRaw;
      case (state)
        SQE_IDLE: begin
          if (txPrev && !txEn && sqeAllowed) begin
            state <= SQE_WAIT;
            cnt   <= '0;
          end
        end
        SQE_WAIT: begin
          if (txEn || !sqeAllowed) begin
            state <= SQE_IDLE;
          end else if (cnt == DELAY_LAST) begin
            state <= SQE_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQE_PULSE: begin
          if (txEn || !sqeAllowed || cnt == WIDTH_LAST) begin
            state <= SQE_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQE_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.sqeOn   = (state == SQE_PULSE);
    strobe.ledFlip = colRaw && !colPrev;
  end

endmodule

// File: rtl/ccu_dp.sv
module ccu_dp
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxActive,
  input  logic       txEn,
  input  logic       fullDuplex,
  input  logic       repeaterMode,
  input  logic       isolate,
  input  logic       sqeReq,
  input  ccuStrobe_t strobe,
  output logic       colRaw,
  output logic       sqeAllowed,
  output logic       crs,
  output logic       col,
  output logic       crsOe,
  output logic       colOe,
  output logic       ledCol
);

  logic halfMode;

  always_comb begin
    halfMode   = !fullDuplex || repeaterMode;
    colRaw     = halfMode && txEn && rxActive;
    sqeAllowed = sqeReq && halfMode && !repeaterMode;
    crs        = rxActive || (halfMode && txEn);
    col        = colRaw || (strobe.sqeOn && sqeAllowed);
    colOe      = !isolate;
    crsOe      = !isolate || repeaterMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledCol <= 1'b0;
    end else if (!halfMode) begin
      ledCol <= 1'b0;
    end else if (strobe.ledFlip) begin
      ledCol <= !ledCol;
    end
  end

endmodule

// File: rtl/carrier_collision_unit.sv
module carrier_collision_unit
  import ccu_pkg::*;
#(
  parameter int SQE_DELAY = 4,
  parameter int SQE_WIDTH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxActive,
  input  logic txEn,
  input  logic fullDuplex,
  input  logic repeaterMode,
  input  logic isolate,
  input  logic sqeReq,
  output logic crs,
  output logic col,
  output logic crsOe,
  output logic colOe,
  output logic ledCol
);

  ccuStrobe_t strobe;
  logic       colRaw;
  logic       sqeAllowed;

  ccu_ctrl #(
    .SQE_DELAY(SQE_DELAY),
    .SQE_WIDTH(SQE_WIDTH)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .txEn      (txEn),
    .sqeAllowed(sqeAllowed),
    .colRaw    (colRaw),
    .strobe    (strobe)
  );

  ccu_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxActive    (rxActive),
    .txEn        (txEn),
    .fullDuplex  (fullDuplex),
    .repeaterMode(repeaterMode),
    .isolate     (isolate),
    .sqeReq      (sqeReq),
    .strobe      (strobe),
    .colRaw      (colRaw),
    .sqeAllowed  (sqeAllowed),
    .crs         (crs),
    .col         (col),
    .crsOe       (crsOe),
    .colOe       (colOe),
    .ledCol      (ledCol)
  );

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker (
  input logic clk,
  input logic rstN,
  input logic rxActive,
  input logic txEn,
  input logic fullDuplex,
  input logic repeaterMode,
  input logic isolate,
  input logic sqeReq,
  input logic crs,
  input logic col,
  input logic crsOe,
  input logic colOe,
  input logic ledCol
);

  AST_FULL_CRS_RX: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && !repeaterMode) |-> (crs == rxActive)); // R1

  AST_HALF_CRS_TX: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && txEn) |-> crs); // R2

  AST_HALF_COL: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && txEn && rxActive) |-> col); // R3

  AST_FULL_NO_COL: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && !repeaterMode) |-> !col); // R4

  AST_RPT_CRS: assert property (@(posedge clk) disable iff (!rstN)
    (repeaterMode && txEn) |-> crs); // R5

  AST_NO_SQE: assert property (@(posedge clk) disable iff (!rstN)
    ((!sqeReq || repeaterMode) && !(txEn && rxActive)) |-> !col); // R7

  AST_ISO_COL: assert property (@(posedge clk) disable iff (!rstN)
    isolate |-> !colOe); // R8

  AST_ISO_CRS: assert property (@(posedge clk) disable iff (!rstN)
    (isolate && !repeaterMode) |-> !crsOe); // R8

  AST_LED_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && !repeaterMode) |=> !ledCol); // R9

endmodule

bind carrier_collision_unit ccu_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rxActive    (rxActive),
  .txEn        (txEn),
  .fullDuplex  (fullDuplex),
  .repeaterMode(repeaterMode),
  .isolate     (isolate),
  .sqeReq      (sqeReq),
  .crs         (crs),
  .col         (col),
  .crsOe       (crsOe),
  .colOe       (colOe),
  .ledCol      (ledCol)
);

// File: tb/carrier_collision_unit_tb_top.sv
`timescale 1ns/1ps
module carrier_collision_unit_tb_top;

  localparam int D = 4;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxActive = 1'b0, txEn = 1'b0, fullDuplex = 1'b0;
  logic repeaterMode = 1'b0, isolate = 1'b0, sqeReq = 1'b0;
  logic crs, col, crsOe, colOe, ledCol;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  carrier_collision_unit #(.SQE_DELAY(D), .SQE_WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .rxActive(rxActive), .txEn(txEn),
    .fullDuplex(fullDuplex), .repeaterMode(repeaterMode), .isolate(isolate),
    .sqeReq(sqeReq), .crs(crs), .col(col), .crsOe(crsOe), .colOe(colOe),
    .ledCol(ledCol)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs a transmit burst and traces col after its falling edge.
  // expPulse selects whether the heartbeat window is expected.
  task automatic sqe_trace(input string req, input logic expPulse);
    @(negedge clk);
    rxActive = 1'b0;
    txEn = 1'b1;
    tick();
    tick();
    txEn = 1'b0;  // next posedge is E0
    for (int j = 0; j <= D + W + 1; j++) begin
      tick();  // now after edge E0+j
      check(req, col, expPulse && (j >= D) && (j < D + W),
            $sformatf("col after E0+%0d", j));
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", ledCol, 1'b0, "ledCol in reset");
    rstN = 1'b1;
    tick();
    tick();
    check("R10", ledCol, 1'b0, "ledCol after reset");
    check("R10", col, 1'b0, "col after reset");

    // R1 R2 R3 R4 R5 R8: exhaustive sweep, heartbeat disabled
    sqeReq = 1'b0;
    for (int v = 0; v < 32; v++) begin
      logic eRx, eTx, eFd, eRp, eIso, half;
      {eIso, eRp, eFd, eTx, eRx} = 5'(v);
      @(negedge clk);
      rxActive = eRx; txEn = eTx; fullDuplex = eFd;
      repeaterMode = eRp; isolate = eIso;
      #1;
      half = !eFd || eRp;
      check(half ? (eRp ? "R5" : "R2") : "R1", crs, eRx | (half & eTx),
            $sformatf("crs v=%0d", v));
      check(half ? "R3" : "R4", col, half & eTx & eRx, $sformatf("col v=%0d", v));
      check("R8", colOe, !eIso, $sformatf("colOe v=%0d", v));
      check("R8", crsOe, !eIso | eRp, $sformatf("crsOe v=%0d", v));
    end

    // R6: heartbeat timing in half duplex
    @(negedge clk);
    isolate = 1'b0; fullDuplex = 1'b0; repeaterMode = 1'b0; sqeReq = 1'b1;
    sqe_trace("R6", 1'b1);

    // R6: pulse dropped when transmit restarts
    @(negedge clk);
    txEn = 1'b1;
    tick();
    txEn = 1'b0;
    tick();  // E0
    txEn = 1'b1;
    tick();
    txEn = 1'b0;
    tick();
    txEn = 1'b1;  // keep re-arming cancelled before D
    for (int j = 0; j < D + W; j++) begin
      tick();
      check("R6", col, 1'b0, $sformatf("col while txEn restarted %0d", j));
    end
    @(negedge clk);
    txEn = 1'b0;
    for (int j = 0; j < D + W + 1; j++) tick();

    // R7: repeater mode suppresses heartbeat
    repeaterMode = 1'b1;
    sqe_trace("R7", 1'b0);
    // R7: request off
    repeaterMode = 1'b0; sqeReq = 1'b0;
    sqe_trace("R7", 1'b0);
    // R4: full duplex, no heartbeat
    fullDuplex = 1'b1; sqeReq = 1'b1;
    sqe_trace("R4", 1'b0);

    // R9: LED toggling in half duplex
    @(negedge clk);
    fullDuplex = 1'b0; sqeReq = 1'b0; txEn = 1'b0; rxActive = 1'b0;
    tick();
    tick();
    check("R9", ledCol, 1'b0, "ledCol start");
    txEn = 1'b1; rxActive = 1'b1;
    tick();
    check("R9", ledCol, 1'b1, "ledCol after first onset");
    tick();
    tick();
    tick();
    check("R9", ledCol, 1'b1, "ledCol during long collision");
    rxActive = 1'b0;
    tick();
    rxActive = 1'b1;
    tick();
    check("R9", ledCol, 1'b0, "ledCol after second onset");
    rxActive = 1'b0;
    tick();
    rxActive = 1'b1;
    tick();
    check("R9", ledCol, 1'b1, "ledCol after third onset");
    fullDuplex = 1'b1;
    tick();
    check("R9", ledCol, 1'b0, "ledCol cleared in full duplex");
    rxActive = 1'b0;
    tick();
    rxActive = 1'b1;
    tick();
    check("R9", ledCol, 1'b0, "ledCol inactive in full duplex");

    // R5: repeater overrides full duplex, LED toggles again
    repeaterMode = 1'b1;
    #1;
    check("R5", col, 1'b1, "col in repeater with fullDuplex=1");
    tick();
    check("R5", ledCol, 1'b1, "ledCol toggles in repeater mode");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule